// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block models one output cell of a programmable sum-of-products device. An AND-array outside the block supplies product-term results. The cell ORs them in groups into sum terms and feeds those sums into two storage elements. It then drives a pin value, gated by an enable term, and returns two feedback signals to the array. A static configuration word sets every option of the cell:

- whether the sum groups are merged into one wide sum;
- D or T behaviour for each storage element;
- where each storage element takes its clock from;
- whether the group preset reaches each storage element;
- whether the second register is bypassed;
- output polarity;
- whether the pin shows a register or a combinational sum.

Everything runs on one system clock. Each register's clock source (the shared clock pin or its own clock product term) is sampled on every system clock edge. A register updates only in the system cycle in which its selected source is first seen high after being low. Each register also has a reset product term. While that term is high, the register's feedback reads 0 in the same cycle, with no clock edge needed, and the stored value is cleared at the next system edge. The active-low `rst_n` models power-up reset.

Top module: `pldmc_macrocell`

## Requirements
- R1: With `cfg_word[0]`=0, register 1 takes the OR of `sum_pt[3:0]` and register 2 takes the OR of `sum_pt[7:4]`. The combinational pin source is the OR of `sum_pt[11:8]`.
- R2: With `cfg_word[0]`=1, register 1 takes the OR of all twelve bits of `sum_pt`. The inputs to register 2 and to the combinational pin source are unchanged.
- R3: `cfg_word[4+i]` sets the mode of register i+1: 0 loads its sum input, 1 inverts the stored value when its sum input is 1 and keeps it otherwise.
- R4: `cfg_word[6+i]`=1 clocks register i+1 from `pin_clk`; 0 clocks it from `ck_pt[i]`. A register changes only after a system edge at which its source is sampled 1 and was sampled 0 at the previous edge. A source held high through reset does not count as a rising edge.
- R5: While `ar_pt[i]` is 1, the feedback of register i+1 reads 0 in the same cycle. The register then holds 0 after the next system edge.
- R6: When `cfg_word[8+i]`=1, `sp_pt`=1 at a clock event of register i+1 sets that register to 1, whatever its mode or sum input. When `cfg_word[8+i]`=0, `sp_pt` is ignored.
- R7: When reset term and preset arrive together, the register ends at 0.
- R8: With `cfg_word[3]`=1, `fb_q2` equals register 2's sum input combinationally. With `cfg_word[3]`=0, it shows register 2's value.
- R9: `pin_drive` equals `oe_pt`. When driven, `pin_out` is the source selected by `cfg_word[1]` (0: register 1 feedback value, 1: combinational sum), XORed with `cfg_word[2]`. When not driven, `pin_out` is 0.
- R10: After `rst_n` is low at an edge, both registers hold 0. With `cfg_word[1]`=0 and the pin driven, `pin_out` therefore equals `cfg_word[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| pin_clk | input | 1 | Shared clock pin level |
| sum_pt | input | 12 | Product terms feeding the three sum groups |
| ck_pt | input | 2 | Clock product term per register |
| ar_pt | input | 2 | Reset product term per register |
| sp_pt | input | 1 | Group synchronous preset term |
| oe_pt | input | 1 | Output-enable product term |
| cfg_word | input | 10 | Static configuration (fields in R1 to R9) |
| pin_out | output | 1 | Pin value, 0 when not driven |
| pin_drive | output | 1 | Pin-driven flag (low means high impedance) |
| fb_q1 | output | 1 | Register 1 feedback to the array |
| fb_q2 | output | 1 | Register 2 (or bypass) feedback to the array |

## Verification
The assertions assume that clock sources are level signals sampled on the system clock. They also assume that a register's events are counted only as the rising edges the cell itself detects, so a source toggling every cycle gives at most one event in every two cycles. The bench changes inputs only at falling edges and keeps `cfg_word` fixed through each block of random cycles, so the configuration is static while the clock sources and reset terms move. Directed steps cover reset and preset arriving together, a merged wide sum with a single active term, bypass feedback, and an ignored preset.

// File: rtl/pldmc_pkg.sv
// Shared types for the output macrocell.
// Assumes two registers per cell. The struct field order fixes the configuration bit
// positions (merge in bit 0, preset enables in bits 9:8).
package pldmc_pkg;
    localparam int NUM_FF = 2;

    typedef struct packed {
        logic [NUM_FF-1:0] sp_en;        // bits 9:8 preset reaches register
        logic [NUM_FF-1:0] pin_clk_sel;  // bits 7:6 1 = clock pin
        logic [NUM_FF-1:0] t_mode;       // bits 5:4 1 = toggle
        logic              bypass2;      // bit 3
        logic              pol;          // bit 2
        logic              pin_src;      // bit 1 1 = combinational sum
        logic              merge;        // bit 0
    } mc_cfg_t;
endpackage

// File: rtl/pldmc_sum_array.sv
// Sum-term stage: ORs product terms in groups of PT_PER_SUM.
// Group 0 feeds register 1, or all groups do when merged. Group 1 feeds register 2.
// Group 2 feeds the combinational pin path.
// Assumes NUM_SUM >= 3.
module pldmc_sum_array #(
    parameter int PT_PER_SUM = 4,
    parameter int NUM_SUM    = 3,
    localparam int PT_W      = PT_PER_SUM * NUM_SUM
) (
    input  logic [PT_W-1:0] pt,
    input  logic            merge,
    output logic            reg1_in,
    output logic            reg2_in,
    output logic            comb_term
);
    logic [NUM_SUM-1:0] sums;

    // One OR gate per sum group.
    for (genvar g = 0; g < NUM_SUM; g++) begin : g_sum
        assign sums[g] = |pt[g*PT_PER_SUM +: PT_PER_SUM];
    end

    // Route the groups to their consumers, widening register 1's input when merged.
    always_comb begin
        reg1_in   = merge ? (|sums) : sums[0];
        reg2_in   = sums[1];
        comb_term = sums[2];
    end
endmodule

// File: rtl/pldmc_edge.sv
// Rising-event detector for a sampled clock-source level.
// Assumes the level is synchronous to clk. The previous sample resets to 1, so a
// source that is high through reset gives no event.
module pldmc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // Remember the level seen at the last system edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    // Flag an event on a low-to-high sample pair.
    assign rise = lvl & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4
endmodule

// File: rtl/pldmc_ff.sv
// One configurable macrocell register: D or T, synchronous preset on its own clock
// event, and a reset term that masks the output at once and clears the stored bit.
// Assumes rise is a one-cycle event from pldmc_edge. Reset term beats preset.
module pldmc_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic d,
    input  logic t_mode,
    input  logic ar,
    input  logic sp,
    output logic q
);
    logic q_reg;
    logic q_next;

    // Choose the value the register takes on its own clock event.
    always_comb begin
        if (sp)          q_next = 1'b1;
        else if (t_mode) q_next = q_reg ^ d;
        else             q_next = d;
    end

    // Store state: power-up clear, reset-term clear, else update on event.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_reg <= 1'b0;
        else if (ar)   q_reg <= 1'b0;
        else if (rise) q_reg <= q_next;
    end

    // The reset term acts without waiting for an edge.
    assign q = ar ? 1'b0 : q_reg;

    AST_AR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ar |=> (q_reg == 1'b0)); // R5
    AST_AR_OVER_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (ar && sp && rise) |=> !q_reg); // R7
    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !ar) |=> $stable(q_reg)); // R4
    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && sp && !ar) |=> q_reg); // R6
    AST_T_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !sp && !ar && t_mode && d) |=> (q_reg != $past(q_reg))); // R3
endmodule

// File: rtl/pldmc_macrocell.sv
// Output macrocell top: sum stage, two clock-event detectors, two registers, an
// optional bypass of register 2, and the polarity and enable stage of the pin.
// Assumes cfg_word is static while in use and that all inputs are synchronous to clk.
module pldmc_macrocell
    import pldmc_pkg::*;
#(
    parameter int PT_PER_SUM = 4,
    parameter int NUM_SUM    = 3,
    localparam int PT_W      = PT_PER_SUM * NUM_SUM,
    localparam int CFG_W     = $bits(mc_cfg_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_clk,
    input  logic [PT_W-1:0]   sum_pt,
    input  logic [NUM_FF-1:0] ck_pt,
    input  logic [NUM_FF-1:0] ar_pt,
    input  logic              sp_pt,
    input  logic              oe_pt,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              pin_out,
    output logic              pin_drive,
    output logic              fb_q1,
    output logic              fb_q2
);
    mc_cfg_t           cfg;
    logic [NUM_FF-1:0] reg_in;
    logic [NUM_FF-1:0] q;
    logic              comb_term;
    logic              pin_val;

    assign cfg = mc_cfg_t'(cfg_word);

    pldmc_sum_array #(
        .PT_PER_SUM (PT_PER_SUM),
        .NUM_SUM    (NUM_SUM)
    ) u_sums (
        .pt        (sum_pt),
        .merge     (cfg.merge),
        .reg1_in   (reg_in[0]),
        .reg2_in   (reg_in[1]),
        .comb_term (comb_term)
    );

    // One clock-source mux, event detector and register per storage element.
    for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
        logic src_lvl;
        logic rise;

        assign src_lvl = cfg.pin_clk_sel[i] ? pin_clk : ck_pt[i];

        pldmc_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (src_lvl),
            .rise  (rise)
        );

        pldmc_ff u_ff (
            .clk    (clk),
            .rst_n  (rst_n),
            .rise   (rise),
            .d      (reg_in[i]),
            .t_mode (cfg.t_mode[i]),
            .ar     (ar_pt[i]),
            .sp     (sp_pt & cfg.sp_en[i]),
            .q      (q[i])
        );
    end

    // Feedback paths, with the optional bypass of register 2.
    always_comb begin
        fb_q1 = q[0];
        fb_q2 = cfg.bypass2 ? reg_in[1] : q[1];
    end

    // Pin stage: source select, polarity, enable.
    always_comb begin
        pin_val   = (cfg.pin_src ? comb_term : q[0]) ^ cfg.pol;
        pin_drive = oe_pt;
        pin_out   = oe_pt ? pin_val : 1'b0;
    end

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_drive |-> !pin_out); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n && !cfg.bypass2) |=> (!fb_q1 && !fb_q2)); // R10
endmodule

// File: tb/pldmc_macrocell_bench.sv
`timescale 1ns/100ps
// Bench: directed corners plus seeded random stimulus, compared with a cycle model.
module pldmc_macrocell_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_clk = 1'b0;
    logic [11:0] sum_pt = '0;
    logic [1:0]  ck_pt = '0;
    logic [1:0]  ar_pt = '0;
    logic        sp_pt = 1'b0;
    logic        oe_pt = 1'b0;
    logic [9:0]  cfg_word = '0;
    logic        pin_out, pin_drive, fb_q1, fb_q2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    logic [1:0] m_q;
    logic [1:0] m_prev;

    always #2.5 clk = ~clk;

    pldmc_macrocell u_pldmc_macrocell (
        .clk(clk), .rst_n(rst_n), .pin_clk(pin_clk), .sum_pt(sum_pt),
        .ck_pt(ck_pt), .ar_pt(ar_pt), .sp_pt(sp_pt), .oe_pt(oe_pt),
        .cfg_word(cfg_word), .pin_out(pin_out), .pin_drive(pin_drive),
        .fb_q1(fb_q1), .fb_q2(fb_q2)
    );

    function automatic logic reg_input(int i);
        if (i == 0) return cfg_word[0] ? (|sum_pt) : (|sum_pt[3:0]);
        return |sum_pt[7:4];
    endfunction

    function automatic logic vis(int i);
        return ar_pt[i] ? 1'b0 : m_q[i];
    endfunction

    task automatic check(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, name, act, exp);
        end
    endtask

    // Check outputs a little after the falling edge, then advance the model past the next rising edge.
    task automatic step(string tag);
        logic e_fb2, e_src, e_pin;
        #1;
        e_fb2 = cfg_word[3] ? reg_input(1) : vis(1);
        e_src = (cfg_word[1] ? (|sum_pt[11:8]) : vis(0)) ^ cfg_word[2];
        e_pin = oe_pt ? e_src : 1'b0;
        check(tag, "fb_q1", fb_q1, vis(0));
        check(tag, "fb_q2", fb_q2, e_fb2);
        check(tag, "pin_out", pin_out, e_pin);
        check(tag, "pin_drive", pin_drive, oe_pt);
        for (int i = 0; i < 2; i++) begin
            logic lvl, rise;
            lvl  = cfg_word[6+i] ? pin_clk : ck_pt[i];
            rise = lvl & ~m_prev[i];
            if (ar_pt[i]) m_q[i] = 1'b0;
            else if (rise) begin
                if (sp_pt && cfg_word[8+i]) m_q[i] = 1'b1;
                else if (cfg_word[4+i])     m_q[i] = m_q[i] ^ reg_input(i);
                else                        m_q[i] = reg_input(i);
            end
            m_prev[i] = lvl;
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1bad5eed));
        m_q = '0;
        m_prev = '1;
        cfg_word = 10'b00_0000_0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: state is clear after reset, the pin shows polarity only
        oe_pt = 1'b1;
        step("R10 reset state");

        // R2: a single active term in the last group still reaches register 1 when merged
        cfg_word = 10'b00_0100_0001;
        sum_pt = 12'h800;
        pin_clk = 1'b0; step("R2 merged");
        pin_clk = 1'b1; step("R2 merged edge");
        pin_clk = 1'b1; step("R2 merged result");
        check("R2 direct", "fb_q1", fb_q1, 1'b1);

        // R1: unmerged, the same term does not reach register 1
        cfg_word = 10'b00_0100_0000;
        pin_clk = 1'b0; step("R1 unmerged");
        pin_clk = 1'b1; step("R1 unmerged edge");
        step("R1 unmerged result");
        check("R1 direct", "fb_q1", fb_q1, 1'b0);

        // R7: reset term and preset together leave 0
        cfg_word = 10'b11_0000_0000;
        sum_pt = '0; ck_pt = 2'b00; step("R7 setup");
        ck_pt = 2'b11; sp_pt = 1'b1; ar_pt = 2'b11; step("R7 clash");
        ar_pt = 2'b00; sp_pt = 1'b0; step("R7 result");
        check("R7 direct", "fb_q2", fb_q2, 1'b0);

        // R6: preset with its enable off is ignored
        cfg_word = 10'b00_0000_0000;
        ck_pt = 2'b00; step("R6 setup");
        ck_pt = 2'b11; sp_pt = 1'b1; step("R6 ignored edge");
        sp_pt = 1'b0; step("R6 ignored result");
        check("R6 direct", "fb_q1", fb_q1, 1'b0);

        // R5: the reset term masks feedback without an edge
        cfg_word = 10'b11_0000_0000;
        ck_pt = 2'b00; step("R5 setup");
        ck_pt = 2'b11; sp_pt = 1'b1; step("R5 preset");
        sp_pt = 1'b0; step("R5 set");
        ar_pt = 2'b01; step("R5 async");
        ar_pt = 2'b00; step("R5 after");

        // R8: bypass shows register 2's sum input combinationally
        cfg_word = 10'b00_0000_1000;
        sum_pt = 12'h010; step("R8 bypass high");
        check("R8 direct", "fb_q2", fb_q2, 1'b1);
        sum_pt = 12'h000; step("R8 bypass low");

        // R1 R3 R4 R6 R9: random configurations and stimulus
        for (int blk = 0; blk < 12; blk++) begin
            cfg_word = 10'($urandom());
            for (int c = 0; c < 300; c++) begin
                sum_pt  = 12'($urandom()) & 12'($urandom());
                pin_clk = 1'($urandom());
                ck_pt   = 2'($urandom());
                ar_pt   = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
                sp_pt   = ($urandom_range(3) == 0);
                oe_pt   = 1'($urandom());
                step("R1 R3 R4 R6 R9 random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule